// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds the eight control bits that steer a chip's system clock tree. It sits on a simple single-clock peripheral bus with a write strobe, write data, a read strobe and read data. Software can change the register only while an external write-protect enable is set. A separate clock-modification lock freezes the bits that could switch or stop the active clock source.

The stored value is not plain storage. Hardware forces some bits regardless of software. Stop-mode entry sets the divide-by-8 select and the sub-oscillator high-drive bit. The high-drive bit is set whenever the sub-oscillator is disabled. When the on-chip oscillator is stopped and the main clock is also stopped, divide-by-8 is held on and an external drive-hold output is raised.

The decoded fields leave the block as separate outputs: clock-output pin function, wait-mode peripheral stop, sub-oscillator drive and enable, main clock stop, divide-by-8 select, and system clock source select. Oscillators, PLL and analog drive circuits lie outside the block. Stop entry is modelled as a one-cycle strobe, and the on-chip oscillator state and the lock as levels.

Top module: `clkctl_reg`

## Requirements
- R1: After reset the register reads 8'h48: bit 6 (divide-by-8) and bit 3 (sub-oscillator high drive) are 1, and all other bits are 0.
- R2: A write with `wr_en`=1 while `prot_wen`=0 leaves every bit unchanged.
- R3: With `prot_wen`=1 and `clk_lock`=0, a write stores `wr_data` into all eight bits, subject only to the forces in R5 to R7.
- R4: While `clk_lock`=1, a protected write leaves bits 7, 5 and 2 at their previous values and stores `wr_data` into bits 6, 4, 3, 1 and 0.
- R5: Whenever bit 4 (sub-oscillator enable) is 0, bit 3 reads 1 and `sub_drive_hi` is 1, whatever was written.
- R6: A cycle with `stop_entry`=1 sets bits 6 and 3 at that clock edge. This force wins over a write in the same cycle.
- R7: While `osc_run`=0 and bit 5 (main clock stop) is 1, bit 6 reads 1, `div8_sel` is 1 and `drive_hold` is 1 in the same cycle. Bit 6 stays 1 in storage afterwards.
- R8: The outputs decode the register as follows:
  - `clkout_sel` = bits [1:0], with 0 for plain I/O, 1 for fC, 2 for f8 and 3 for f32.
  - `wait_periph_stop` = bit 2.
  - `sub_drive_hi` = bit 3.
  - `sub_osc_en` = bit 4.
  - `main_clk_stop` = bit 5.
  - `div8_sel` = bit 6.
  - `sys_clk_sub` = bit 7, where 1 selects the sub clock.
- R9: `rd_data` shows the register, with the forces already applied, in the same cycle `rd_en`=1. It is 8'h00 while `rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, zero when not reading |
| prot_wen | input | 1 | Write-protect enable; writes take effect only when 1 |
| clk_lock | input | 1 | Clock-modification lock; freezes bits 7, 5 and 2 |
| stop_entry | input | 1 | One-cycle strobe marking stop-mode entry |
| osc_run | input | 1 | On-chip oscillator running (1) or stopped (0) |
| clkout_sel | output | 2 | Clock output pin function |
| wait_periph_stop | output | 1 | Peripheral clock stops in wait mode |
| sub_drive_hi | output | 1 | Sub-oscillator high drive |
| sub_osc_en | output | 1 | Sub-oscillator enable |
| main_clk_stop | output | 1 | Main clock stop |
| div8_sel | output | 1 | Divide-by-8 select |
| sys_clk_sub | output | 1 | System clock source is the sub clock |
| drive_hold | output | 1 | Main drive capacity held high by hardware |

## Verification
The bench builds the block with its default parameters. These are the reset value 8'h48 and a lock mask covering bits 7, 5 and 2, so the lock freezes exactly the clock-switching bits and the stored value after reset is the one R1 names. With these defaults, one vector walk reaches several situations:
- a blocked write;
- a lock that splits a write between kept and written bits;
- a stop strobe coinciding with a write;
- an oscillator-off write that stops the main clock.

Directed steps then cover an oscillator drop with no write, the read strobe low, the full output decode, and a reset in mid-run.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int REG_W = 8;

  localparam int B_CKO_LO = 0;
  localparam int B_CKO_HI = 1;
  localparam int B_WAITSTOP = 2;
  localparam int B_SUBDRV = 3;
  localparam int B_SUBEN = 4;
  localparam int B_MAINSTOP = 5;
  localparam int B_DIV8 = 6;
  localparam int B_SYSSUB = 7;

  typedef logic [REG_W-1:0] ctl_word_t;

  typedef enum logic [1:0] {
    CKO_PORT = 2'b00,
    CKO_FC   = 2'b01,
    CKO_F8   = 2'b10,
    CKO_F32  = 2'b11
  } cko_sel_e;
endpackage

// File: rtl/clkctl_rst_sync.sv
module clkctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkctl_wr_gate.sv
module clkctl_wr_gate
  import clkctl_pkg::*;
#(
  parameter ctl_word_t LOCK_MASK = 8'b1010_0100
) (
  input  ctl_word_t cur,
  input  ctl_word_t wdata,
  input  logic      wr_en,
  input  logic      prot_wen,
  input  logic      clk_lock,
  output ctl_word_t cand
);
  logic      accept;
  ctl_word_t keep_mask;

  always_comb begin
    accept    = wr_en & prot_wen;
    keep_mask = clk_lock ? LOCK_MASK : '0;
    if (accept) cand = (cur & keep_mask) | (wdata & ~keep_mask);
    else        cand = cur;
  end
endmodule

// File: rtl/clkctl_force.sv
module clkctl_force
  import clkctl_pkg::*;
(
  input  ctl_word_t cand,
  input  logic      stop_entry,
  input  logic      osc_run,
  output ctl_word_t forced
);
  always_comb begin
    forced = cand;
    if (stop_entry) begin
      forced[B_DIV8]   = 1'b1;
      forced[B_SUBDRV] = 1'b1;
    end
    if (!cand[B_SUBEN]) forced[B_SUBDRV] = 1'b1;
    if (cand[B_MAINSTOP] && !osc_run) forced[B_DIV8] = 1'b1;
  end
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
  import clkctl_pkg::*;
#(
  parameter ctl_word_t RESET_VAL = 8'b0100_1000,
  parameter ctl_word_t LOCK_MASK = 8'b1010_0100,
  parameter int        SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       prot_wen,
  input  logic       clk_lock,
  input  logic       stop_entry,
  input  logic       osc_run,
  output logic [1:0] clkout_sel,
  output logic       wait_periph_stop,
  output logic       sub_drive_hi,
  output logic       sub_osc_en,
  output logic       main_clk_stop,
  output logic       div8_sel,
  output logic       sys_clk_sub,
  output logic       drive_hold
);
  logic      rst_ns;
  ctl_word_t ctl_q, ctl_cand, ctl_d, ctl_view;

  clkctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  clkctl_wr_gate #(.LOCK_MASK(LOCK_MASK)) u_gate (
    .cur(ctl_q), .wdata(wr_data), .wr_en(wr_en),
    .prot_wen(prot_wen), .clk_lock(clk_lock), .cand(ctl_cand)
  );

  clkctl_force u_force_nxt (
    .cand(ctl_cand), .stop_entry(stop_entry), .osc_run(osc_run), .forced(ctl_d)
  );

  clkctl_force u_force_view (
    .cand(ctl_q), .stop_entry(1'b0), .osc_run(osc_run), .forced(ctl_view)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) ctl_q <= RESET_VAL;
    else         ctl_q <= ctl_d;
  end

  always_comb begin
    rd_data          = rd_en ? ctl_view : '0;
    clkout_sel       = ctl_view[B_CKO_HI:B_CKO_LO];
    wait_periph_stop = ctl_view[B_WAITSTOP];
    sub_drive_hi     = ctl_view[B_SUBDRV];
    sub_osc_en       = ctl_view[B_SUBEN];
    main_clk_stop    = ctl_view[B_MAINSTOP];
    div8_sel         = ctl_view[B_DIV8];
    sys_clk_sub      = ctl_view[B_SYSSUB];
    drive_hold       = ctl_q[B_MAINSTOP] & ~osc_run;
  end

  // R2: blocked write with nothing forcing leaves storage unchanged
  a_r2_protect_blocks: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && !prot_wen && !stop_entry && osc_run && ctl_q[B_SUBEN])
      |=> $stable(ctl_q));

  // R4: locked bits survive a protected write
  a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && prot_wen && clk_lock && !stop_entry)
      |=> ((ctl_q & LOCK_MASK) == ($past(ctl_q) & LOCK_MASK)));

  // R5: disabled sub-oscillator implies high drive
  a_r5_subdrv_forced: assert property (@(posedge clk) disable iff (!rst_ns)
    !sub_osc_en |-> sub_drive_hi);

  // R6: stop entry wins over any write
  a_r6_stop_force: assert property (@(posedge clk) disable iff (!rst_ns)
    stop_entry |=> (ctl_q[B_DIV8] && ctl_q[B_SUBDRV]));

  // R7: oscillator off plus main stop holds divide-by-8 and drive
  a_r7_osc_off_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (!osc_run && main_clk_stop) |-> (div8_sel && drive_hold));

  // R9: idle read bus is zero
  a_r9_rd_idle: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd_en |-> (rd_data == 8'h00));
endmodule

// File: tb/clkctl_reg_tb.sv
module clkctl_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, prot_wen, clk_lock, stop_entry, osc_run;
  logic [7:0] wr_data, rd_data;
  logic [1:0] clkout_sel;
  logic       wait_periph_stop, sub_drive_hi, sub_osc_en, main_clk_stop;
  logic       div8_sel, sys_clk_sub, drive_hold;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  clkctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .prot_wen(prot_wen),
    .clk_lock(clk_lock), .stop_entry(stop_entry), .osc_run(osc_run),
    .clkout_sel(clkout_sel), .wait_periph_stop(wait_periph_stop),
    .sub_drive_hi(sub_drive_hi), .sub_osc_en(sub_osc_en),
    .main_clk_stop(main_clk_stop), .div8_sel(div8_sel),
    .sys_clk_sub(sys_clk_sub), .drive_hold(drive_hold)
  );

  // {prot, lock, osc_run, stop, wdata[7:0], expected[7:0]}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {4'b0010, 8'hFF, 8'h48},  // R2 blocked
    {4'b1010, 8'h13, 8'h13},  // R3 plain write
    {4'b1010, 8'h03, 8'h0B},  // R5 bit3 forced
    {4'b1010, 8'hB6, 8'hB6},  // R3
    {4'b1110, 8'h51, 8'hF5},  // R4 lock split
    {4'b1110, 8'h00, 8'hAC},  // R4 + R5
    {4'b1011, 8'h10, 8'h58},  // R6 stop beats write
    {4'b1000, 8'h30, 8'h70},  // R7 osc off, main stop
    {4'b0000, 8'h00, 8'h70},  // R2 blocked while osc off
    {4'b1010, 8'h32, 8'h32}   // R3
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; stop_entry = 0; prot_wen = 0; clk_lock = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; rd_en = 1; osc_run = 1; wr_data = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 reset value", rd_data, 8'h48);
    check("R1 reset outputs",
          {sys_clk_sub, div8_sel, main_clk_stop, sub_osc_en, sub_drive_hi, wait_periph_stop, clkout_sel},
          8'h48);

    for (int i = 0; i < NV; i++) begin
      prot_wen = VEC[i][19]; clk_lock = VEC[i][18];
      osc_run = VEC[i][17]; stop_entry = VEC[i][16];
      wr_data = VEC[i][15:8]; wr_en = 1;
      @(negedge clk);
      idle();
      check($sformatf("R2-6 vector %0d", i), rd_data, VEC[i][7:0]);
      if (i == 8) check("R7 drive_hold", {7'd0, drive_hold}, 8'h01);
    end

    // R7: oscillator drops with no write; visible in the same cycle
    osc_run = 0;
    #1;
    check("R7 same-cycle view", rd_data, 8'h72);
    check("R7 drive_hold", {7'd0, drive_hold}, 8'h01);
    @(negedge clk);
    osc_run = 1;
    #1;
    check("R7 bit6 retained", rd_data, 8'h72);
    check("R7 drive released", {7'd0, drive_hold}, 8'h00);

    // R9: read strobe low
    rd_en = 0;
    #1;
    check("R9 idle read", rd_data, 8'h00);
    rd_en = 1;

    // R8: output decode of 1001_1110
    prot_wen = 1; wr_data = 8'h9E; wr_en = 1;
    @(negedge clk);
    idle();
    check("R3 write 9E", rd_data, 8'h9E);
    check("R8 clkout_sel f8", {6'd0, clkout_sel}, 8'h02);
    check("R8 single bits",
          {3'd0, sys_clk_sub, div8_sel, main_clk_stop, sub_osc_en, wait_periph_stop},
          8'b0001_0011);
    check("R8 sub drive", {7'd0, sub_drive_hi}, 8'h01);

    // R9: read mirrors immediately after a write in the prior cycle
    prot_wen = 1; wr_data = 8'h11; wr_en = 1;
    @(negedge clk);
    idle();
    check("R9 read after write", rd_data, 8'h11);
    check("R8 clkout_sel fC", {6'd0, clkout_sel}, 8'h01);

    // R1: reset mid-run
    rst_n = 0;
    @(negedge clk);
    check("R1 async reset", rd_data, 8'h48);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 after release", rd_data, 8'h48);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule